// File: doc/BRIEF.md
# Cipher Engine Status and Access Monitor

This block holds the status flags and the access-violation record for a block-cipher peripheral. The cipher engine sends one-cycle event pulses when it finishes a data block, completes an authentication tag, ends a padding phase or finds a bad padding length. The block turns each event into a sticky flag, and each flag has its own set of clear sources. The bus decoder sends one-cycle strobes for accesses to the peripheral's registers. The block compares each strobe with the engine's current phase and records any access that is not allowed.

Software reads the result as one read-only 32-bit status word. Flag positions are fixed, because the interrupt mask that comes in on `irq_mask` uses the same bit layout. The interrupt line is the masked OR of the status word, registered once. The status word has no read strobe, so reading it changes no state.

Top module: `cipher_status_mon`

## Requirements
- R1: After a synchronous reset the status word is zero and `irq` is 0. Bits 31:19, 11:9 and 7:1 always read 0.
- R2: Bit 0 (data ready) is 1 from the cycle after `ev_data_done`. It returns to 0 after `cmd_start`, `cmd_swrst` or `rd_out_data`.
- R3: When `cfg_last_out` is 1 and `cfg_start_mode` is 0 or 1, `wr_in_data` also clears data ready. With `cfg_last_out` at 0, or with `cfg_start_mode` at 2, the write leaves data ready unchanged.
- R4: Bit 16 (tag ready) is 1 from the cycle after `ev_tag_done`. It returns to 0 after `rd_tag`, `cmd_start` or `wr_key`.
- R5: Bit 17 (padding over) sets on `ev_pad_end` and bit 18 (padding length error) sets on `ev_pad_len_err`. Both clear on `cmd_start` or `cmd_swrst`.
- R6: Bits 15:12 record the type of an illegal access. The codes are:
  - 0: `wr_in_data` while `ph_processing` and `cfg_start_mode`==2
  - 1: `rd_out_data` while `ph_processing`
  - 2: `wr_mode` while `ph_processing`
  - 3: `rd_out_data` while `ph_subkey`
  - 4: `wr_mode` while `ph_subkey`
  - 5: `rd_wo_reg` in any phase
- R7: Bit 8 becomes 1 on any illegal access and stays 1. Bits 15:12 hold only the most recent type. Only `cmd_swrst` clears bit 8 and bits 15:12.
- R8: If a flag is set and cleared in the same cycle, the set wins. If several violations occur in one cycle, the highest code is recorded.
- R9: `irq` is 1 one cycle after any status bit and its `irq_mask` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_data_done | input | 1 | Engine finished a data block |
| ev_tag_done | input | 1 | Tag generation complete |
| ev_pad_end | input | 1 | Padding phase finished |
| ev_pad_len_err | input | 1 | Invalid padding length seen |
| ph_processing | input | 1 | Engine is processing data |
| ph_subkey | input | 1 | Engine is generating subkeys |
| cfg_last_out | input | 1 | Last-output-data mode enable |
| cfg_start_mode | input | 2 | 0 manual, 1 auto, 2 DMA-driven start |
| wr_in_data | input | 1 | Write to any input data register |
| rd_out_data | input | 1 | Read of any output data register |
| wr_mode | input | 1 | Write to the mode register |
| wr_key | input | 1 | Write of a new key |
| rd_tag | input | 1 | Read of the tag registers |
| rd_wo_reg | input | 1 | Read of a write-only register |
| cmd_start | input | 1 | Start command |
| cmd_swrst | input | 1 | Software reset command |
| irq_mask | input | 32 | Interrupt enable, one bit per status bit |
| status_word | output | 32 | Read-only status word |
| irq | output | 1 | Masked interrupt request |

## Verification
A flag whose clear term is wrong shows up at the port in the cycle after the event, because the status word comes straight from the flag registers. The same holds for a wrong priority between set and clear, or for an access-type register that takes the wrong violation. A wrong interrupt enable shows up one cycle later on `irq`. The bench checks every phase, start mode and strobe combination. It applies a software reset before each combination so that one result cannot hide a fault in another.

// File: rtl/cipher_status_pkg.sv
package cipher_status_pkg;
  localparam int STAT_W    = 32;
  localparam int CODE_W    = 4;
  localparam int NUM_VIOL  = 6;
  localparam int POS_DRDY  = 0;
  localparam int POS_DET   = 8;
  localparam int POS_TYPE  = 12;
  localparam int POS_TAG   = 16;
  localparam int POS_PEND  = 17;
  localparam int POS_PERR  = 18;
  localparam int NUM_FLAGS = 4;
  // flag index within the sticky bank
  localparam int F_DRDY = 0;
  localparam int F_TAG  = 1;
  localparam int F_PEND = 2;
  localparam int F_PERR = 3;
  // start-mode encodings
  localparam logic [1:0] SM_MANUAL = 2'd0;
  localparam logic [1:0] SM_AUTO   = 2'd1;
  localparam logic [1:0] SM_DMA    = 2'd2;
  typedef enum logic [CODE_W-1:0] {
    V_IN_WR_PROC   = 4'd0,
    V_OUT_RD_PROC  = 4'd1,
    V_MODE_WR_PROC = 4'd2,
    V_OUT_RD_SUBK  = 4'd3,
    V_MODE_WR_SUBK = 4'd4,
    V_WO_RD        = 4'd5
  } viol_code_t;
endpackage

// File: rtl/cs_sticky_bank.sv
module cs_sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q_r;
    always_ff @(posedge clk) begin
      if (rst)           q_r <= 1'b0;
      else if (set_i[i]) q_r <= 1'b1;
      else if (clr_i[i]) q_r <= 1'b0;
    end
    assign q_o[i] = q_r;
  end
endmodule

// File: rtl/cs_access_classifier.sv
module cs_access_classifier
  import cipher_status_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              ph_processing,
  input  logic              ph_subkey,
  input  logic [MODE_W-1:0] start_mode,
  input  logic              wr_in_data,
  input  logic              rd_out_data,
  input  logic              wr_mode,
  input  logic              rd_wo_reg,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o
);
  logic [NUM_VIOL-1:0] cond;

  always_comb begin
    cond = '0;
    cond[V_IN_WR_PROC]   = wr_in_data && ph_processing && (start_mode == MODE_W'(SM_DMA));
    cond[V_OUT_RD_PROC]  = rd_out_data && ph_processing;
    cond[V_MODE_WR_PROC] = wr_mode && ph_processing;
    cond[V_OUT_RD_SUBK]  = rd_out_data && ph_subkey;
    cond[V_MODE_WR_SUBK] = wr_mode && ph_subkey;
    cond[V_WO_RD]        = rd_wo_reg;
  end

  // highest index wins: later loop iterations overwrite
  always_comb begin
    code_o = '0;
    for (int k = 0; k < NUM_VIOL; k++)
      if (cond[k]) code_o = CODE_W'(k);
  end

  assign hit_o = |cond;
endmodule

// File: rtl/cs_access_log.sv
module cs_access_log
  import cipher_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              swrst_i,
  output logic              det_o,
  output logic [CODE_W-1:0] type_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      det_o  <= 1'b0;
      type_o <= '0;
    end else if (hit_i) begin
      det_o  <= 1'b1;
      type_o <= code_i;
    end else if (swrst_i) begin
      det_o  <= 1'b0;
      type_o <= '0;
    end
  end
endmodule

// File: rtl/cs_irq_gen.sv
module cs_irq_gen #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status_i & mask_i);
  end
endmodule

// File: rtl/cipher_status_mon.sv
module cipher_status_mon
  import cipher_status_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_data_done,
  input  logic              ev_tag_done,
  input  logic              ev_pad_end,
  input  logic              ev_pad_len_err,
  input  logic              ph_processing,
  input  logic              ph_subkey,
  input  logic              cfg_last_out,
  input  logic [MODE_W-1:0] cfg_start_mode,
  input  logic              wr_in_data,
  input  logic              rd_out_data,
  input  logic              wr_mode,
  input  logic              wr_key,
  input  logic              rd_tag,
  input  logic              rd_wo_reg,
  input  logic              cmd_start,
  input  logic              cmd_swrst,
  input  logic [STAT_W-1:0] irq_mask,
  output logic [STAT_W-1:0] status_word,
  output logic              irq
);
  logic [NUM_FLAGS-1:0] f_set, f_clr, f_q;
  logic                 v_hit, det_q;
  logic [CODE_W-1:0]    v_code, type_q;
  logic                 lod_clear;

  assign lod_clear = cfg_last_out && wr_in_data &&
                     ((cfg_start_mode == MODE_W'(SM_MANUAL)) ||
                      (cfg_start_mode == MODE_W'(SM_AUTO)));

  always_comb begin
    f_set         = '0;
    f_set[F_DRDY] = ev_data_done;
    f_set[F_TAG]  = ev_tag_done;
    f_set[F_PEND] = ev_pad_end;
    f_set[F_PERR] = ev_pad_len_err;
    f_clr         = '0;
    f_clr[F_DRDY] = cmd_start || cmd_swrst || rd_out_data || lod_clear;
    f_clr[F_TAG]  = rd_tag || cmd_start || wr_key;
    f_clr[F_PEND] = cmd_start || cmd_swrst;
    f_clr[F_PERR] = cmd_start || cmd_swrst;
  end

  cs_sticky_bank #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .set_i(f_set), .clr_i(f_clr), .q_o(f_q)
  );

  cs_access_classifier #(.MODE_W(MODE_W)) u_class (
    .ph_processing(ph_processing), .ph_subkey(ph_subkey),
    .start_mode(cfg_start_mode), .wr_in_data(wr_in_data),
    .rd_out_data(rd_out_data), .wr_mode(wr_mode), .rd_wo_reg(rd_wo_reg),
    .hit_o(v_hit), .code_o(v_code)
  );

  cs_access_log u_log (
    .clk(clk), .rst(rst), .hit_i(v_hit), .code_i(v_code),
    .swrst_i(cmd_swrst), .det_o(det_q), .type_o(type_q)
  );

  always_comb begin
    status_word = '0;
    status_word[POS_DRDY]                 = f_q[F_DRDY];
    status_word[POS_DET]                  = det_q;
    status_word[POS_TYPE +: CODE_W]       = type_q;
    status_word[POS_TAG]                  = f_q[F_TAG];
    status_word[POS_PEND]                 = f_q[F_PEND];
    status_word[POS_PERR]                 = f_q[F_PERR];
  end

  cs_irq_gen #(.W(STAT_W)) u_irq (
    .clk(clk), .rst(rst), .status_i(status_word), .mask_i(irq_mask), .irq_o(irq)
  );
endmodule

// File: rtl/cipher_status_chk.sv
module cipher_status_chk
  import cipher_status_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ev_data_done,
  input logic              ev_tag_done,
  input logic              cmd_start,
  input logic              cmd_swrst,
  input logic              rd_wo_reg,
  input logic [STAT_W-1:0] irq_mask,
  input logic [STAT_W-1:0] status_word,
  input logic              irq
);
  localparam logic [STAT_W-1:0] RSVD = ~(STAT_W'(1) | (STAT_W'(1) << POS_DET) |
    (STAT_W'(15) << POS_TYPE) | (STAT_W'(7) << POS_TAG));

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (status_word == '0 && !irq));
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst) (status_word & RSVD) == '0);
  // R2
  drdy_set_chk: assert property (@(posedge clk) disable iff (rst) ev_data_done |=> status_word[POS_DRDY]);
  // R2
  drdy_start_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !ev_data_done) |=> !status_word[POS_DRDY]);
  // R4
  tag_set_chk: assert property (@(posedge clk) disable iff (rst) ev_tag_done |=> status_word[POS_TAG]);
  // R7
  det_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (status_word[POS_DET] && !cmd_swrst) |=> status_word[POS_DET]);
  // R6
  wo_code_chk: assert property (@(posedge clk) disable iff (rst)
    rd_wo_reg |=> (status_word[POS_DET] && status_word[POS_TYPE +: CODE_W] == CODE_W'(V_WO_RD)));
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(status_word) & $past(irq_mask))));
endmodule

bind cipher_status_mon cipher_status_chk u_chk (
  .clk(clk), .rst(rst), .ev_data_done(ev_data_done), .ev_tag_done(ev_tag_done),
  .cmd_start(cmd_start), .cmd_swrst(cmd_swrst), .rd_wo_reg(rd_wo_reg),
  .irq_mask(irq_mask), .status_word(status_word), .irq(irq)
);

// File: tb/tb_cipher_status_mon.sv
module tb_cipher_status_mon;
  logic clk = 1'b0;
  logic rst;
  logic ev_data_done, ev_tag_done, ev_pad_end, ev_pad_len_err;
  logic ph_processing, ph_subkey, cfg_last_out;
  logic [1:0] cfg_start_mode;
  logic wr_in_data, rd_out_data, wr_mode, wr_key, rd_tag, rd_wo_reg, cmd_start, cmd_swrst;
  logic [31:0] irq_mask, status_word;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cipher_status_mon dut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    {ev_data_done, ev_tag_done, ev_pad_end, ev_pad_len_err} = '0;
    {wr_in_data, rd_out_data, wr_mode, wr_key, rd_tag, rd_wo_reg, cmd_start, cmd_swrst} = '0;
  endtask

  // inputs set before this call are held for one edge, then removed
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  function automatic int exp_code(bit p, bit s, int sm, bit wi, bit ro, bit wm, bit rw);
    int c = -1;
    if (wi && p && sm == 2) c = 0;
    if (ro && p) c = 1;
    if (wm && p) c = 2;
    if (ro && s) c = 3;
    if (wm && s) c = 4;
    if (rw) c = 5;
    return c;
  endfunction

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1; ph_processing = 0; ph_subkey = 0; cfg_last_out = 0;
    cfg_start_mode = 0; irq_mask = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(status_word, 32'h0, "R1 reset status");
    chk({31'b0, irq}, 32'h0, "R1 reset irq");

    // R2 set and three clear sources
    ev_data_done = 1; tick(); chk(status_word, 32'h1, "R2 set");
    cmd_start = 1;    tick(); chk(status_word, 32'h0, "R2 start clear");
    ev_data_done = 1; tick(); cmd_swrst = 1; tick(); chk(status_word, 32'h0, "R2 swrst clear");
    ev_data_done = 1; tick(); rd_out_data = 1; tick(); chk(status_word, 32'h0, "R2 out read clear");

    // R3 input write clear depends on last-out and start mode
    for (int lod = 0; lod < 2; lod++)
      for (int sm = 0; sm < 3; sm++) begin
        cfg_last_out = lod[0]; cfg_start_mode = sm[1:0];
        cmd_swrst = 1; tick();
        ev_data_done = 1; tick();
        wr_in_data = 1; tick();
        chk({31'b0, status_word[0]}, (lod == 1 && sm < 2) ? 32'h0 : 32'h1, "R3 input write");
      end
    cfg_last_out = 0; cfg_start_mode = 0; cmd_swrst = 1; tick();

    // R4 tag flag
    ev_tag_done = 1; tick(); chk(status_word, 32'h1_0000, "R4 set");
    rd_tag = 1; tick(); chk(status_word, 32'h0, "R4 tag read clear");
    ev_tag_done = 1; tick(); wr_key = 1; tick(); chk(status_word, 32'h0, "R4 key clear");
    ev_tag_done = 1; tick(); cmd_start = 1; tick(); chk(status_word, 32'h0, "R4 start clear");

    // R5 padding flags
    ev_pad_end = 1; ev_pad_len_err = 1; tick(); chk(status_word, 32'h6_0000, "R5 set");
    cmd_start = 1; tick(); chk(status_word, 32'h0, "R5 start clear");
    ev_pad_end = 1; tick(); cmd_swrst = 1; tick(); chk(status_word, 32'h0, "R5 swrst clear");

    // R8 set beats clear
    ev_data_done = 1; cmd_start = 1; ev_tag_done = 1; rd_tag = 1; tick();
    chk(status_word, 32'h1_0001, "R8 set wins");
    cmd_start = 1; tick();

    // R6 / R8 sweep of phases, start modes and strobes
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 2; s++)
        for (int sm = 0; sm < 3; sm++)
          for (int st = 0; st < 16; st++) begin
            int c;
            logic [31:0] e;
            cmd_swrst = 1; tick();
            ph_processing = p[0]; ph_subkey = s[0]; cfg_start_mode = sm[1:0];
            wr_in_data = st[0]; rd_out_data = st[1]; wr_mode = st[2]; rd_wo_reg = st[3];
            tick();
            c = exp_code(p[0], s[0], sm, st[0], st[1], st[2], st[3]);
            e = (c < 0) ? 32'h0 : (32'h100 | (32'(c) << 12));
            chk(status_word, e, "R6 classify");
          end
    ph_processing = 0; ph_subkey = 0; cfg_start_mode = 0;

    // R7 last type kept, sticky bit, start does not clear
    cmd_swrst = 1; tick();
    rd_wo_reg = 1; tick();
    ph_processing = 1; wr_mode = 1; tick(); ph_processing = 0;
    chk(status_word, 32'h2100, "R7 last type");
    cmd_start = 1; tick(); chk(status_word, 32'h2100, "R7 start keeps");
    tick(); chk(status_word, 32'h2100, "R7 sticky idle");
    cmd_swrst = 1; tick(); chk(status_word, 32'h0, "R7 swrst clear");

    // R9 interrupt masking and latency
    irq_mask = 32'h1_0000;
    ev_data_done = 1; tick(); tick(); chk({31'b0, irq}, 32'h0, "R9 masked bit");
    ev_tag_done = 1; tick(); chk({31'b0, irq}, 32'h0, "R9 one cycle later");
    tick(); chk({31'b0, irq}, 32'h1, "R9 asserted");
    rd_tag = 1; tick(); chk({31'b0, irq}, 32'h1, "R9 lag on clear");
    tick(); chk({31'b0, irq}, 32'h0, "R9 deasserted");
    irq_mask = '1; tick(); chk({31'b0, irq}, 32'h1, "R9 full mask");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule